// File: doc/BRIEF.md
# Serial Control-Port Register Slave

This block gives a host processor byte-wide access to the control and status registers of an audio receiver over a four-wire serial port. The port runs in SPI mode 0. The serial clock, chip select and data input are synchronised into the system clock, and their edges are detected there. The serial clock must therefore stay high and low for several system clock cycles each.

A transaction is framed by chip select being low. The first byte names the device and the direction. A write then carries a pointer byte and any number of data bytes. A read sends no pointer byte. It streams data from the pointer that the last write left behind.

Ten control bytes leave the block as a flat vector, and the run-enable bit has its own output. Twenty-nine status bytes come in from the surrounding logic and can be read back but not written. An identification byte sits at the top of the address space.

Top module: `ctl_port_slave`

## Requirements
- R1: The first byte of a transaction is the address byte. Its bits 7:1 must equal 7'b0010000. Its bit 0 selects the direction: 1 means read and 0 means write, so 0x20 opens a write and 0x21 opens a read.
- R2: In a write, the byte after the address byte loads the pointer. Bits 6:0 select the register and bit 7 is the increment flag. Both persist after chip select goes high.
- R3: Each further byte of a write is stored in the register the pointer selects. With the increment flag set, the pointer advances by one after each data byte. With the flag clear, the pointer stays where it is.
- R4: A read returns bytes MSB first, starting at the current pointer, with no pointer byte. Data is sampled on the rising edge of the serial clock and changes on the falling edge. The same increment rule applies after each byte.
- R5: Registers 0x00 to 0x09 are read/write. Register k appears on `ctrl_o[8k+7:8k]`, and `run_o` mirrors bit 7 of register 0x04.
- R6: Registers 0x0A to 0x26 are read-only. Register 0x0A+i returns `status_i[8i+7:8i]`, and writes to these registers leave `ctrl_o` unchanged.
- R7: Register 0x7F reads as {4'h2, `version_i`}. Every other unimplemented address reads 0x00. Writes to either kind leave `ctrl_o` unchanged.
- R8: With the increment flag set, the pointer wraps from 0x7F to 0x00.
- R9: If the address byte does not match, the rest of the transaction is ignored until chip select goes high. In that case nothing is written, the pointer is unchanged and `miso_oe_o` stays low.
- R10: `miso_oe_o` is high only in the data phase of a matched read. Chip select going high ends the transaction, even in the middle of a byte, and the next transaction starts again with an address byte.
- R11: After reset, all control registers are 0x00, `run_o` is 0, the pointer is 0x00 with the increment flag clear, and `miso_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output enable for miso_o |
| status_i | input | 232 | Read-only status bytes 0x0A..0x26, byte i at bits 8i+7:8i |
| version_i | input | 4 | Version nibble returned in register 0x7F |
| ctrl_o | output | 80 | Control registers 0x00..0x09, register k at bits 8k+7:8k |
| run_o | output | 1 | Run-enable bit, register 0x04 bit 7 |

## Verification
Chip select and the serial clock pass through two synchroniser flops and an edge-detect flop before they take effect.

- A register write lands two system cycles after the synchronised rising edge that completes its byte.
- The next read byte is loaded one cycle after the previous byte completes, and each data bit moves on a synchronised falling edge.
- `miso_oe_o` drops about three cycles after chip select rises.

The bench holds each serial clock phase for eight system cycles and samples `miso_o` just before each rising edge, well after every one of these latencies. It compares `ctrl_o`, `run_o` and `miso_oe_o` with its model on every clock only once chip select has been idle for sixteen cycles.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
  typedef enum logic [2:0] {
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } seq_st_e;
endpackage

// File: rtl/ctl_port_shifter.sv
module ctl_port_shifter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  input  logic       tx_load_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_en_i,
  output logic       miso_o,
  output logic       active_o,
  output logic       byte_valid_o,
  output logic [7:0] rx_byte_o
);
  logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, mosi_sync;
  logic sclk_s, cs_s, mosi_s, sclk_q;
  logic rise, fall;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sync <= '0;
      cs_sync   <= '1;
      mosi_sync <= '0;
      sclk_q    <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_i};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_ni};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
      sclk_q    <= sclk_s;
    end
  end

  assign sclk_s   = sclk_sync[SYNC_STAGES-1];
  assign cs_s     = cs_sync[SYNC_STAGES-1];
  assign mosi_s   = mosi_sync[SYNC_STAGES-1];
  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign active_o = ~cs_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt      <= '0;
      rx_sh        <= '0;
      rx_byte_o    <= '0;
      byte_valid_o <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      if (!active_o) begin
        bit_cnt <= '0;
      end else if (rise) begin
        rx_sh   <= {rx_sh[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_valid_o <= 1'b1;
          rx_byte_o    <= {rx_sh, mosi_s};
        end
      end
    end
  end

  // no shift on the fall after the last bit: the next byte is loaded there
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 tx_sh <= '0;
    else if (tx_load_i)                          tx_sh <= tx_data_i;
    else if (active_o && fall && bit_cnt != '0)  tx_sh <= {tx_sh[6:0], 1'b0};
  end

  assign miso_o = tx_en_i & tx_sh[7];

  AST_REALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |=> bit_cnt == '0);  // R10
endmodule

// File: rtl/ctl_port_seq.sv
module ctl_port_seq
  import ctl_port_pkg::*;
#(
  parameter int          ADDR_W = 7,
  parameter logic [6:0]  DEV_ID = 7'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        rx_byte_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wr_data_o,
  output logic              tx_load_o,
  output logic              tx_en_o
);
  seq_st_e st_q;
  logic [ADDR_W-1:0] ptr_q;
  logic inc_q;
  logic data_phase;

  assign data_phase = (st_q == ST_WDATA) || (st_q == ST_RDATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_ADDR;
      ptr_q     <= '0;
      inc_q     <= 1'b0;
      tx_load_o <= 1'b0;
    end else begin
      tx_load_o <= byte_valid_i & active_i;
      if (!active_i) begin
        st_q <= ST_ADDR;
      end else if (byte_valid_i) begin
        unique case (st_q)
          ST_ADDR:  st_q <= (rx_byte_i[7:1] != DEV_ID) ? ST_SKIP :
                            (rx_byte_i[0] ? ST_RDATA : ST_PTR);
          ST_PTR: begin
            ptr_q <= rx_byte_i[ADDR_W-1:0];
            inc_q <= rx_byte_i[7];
            st_q  <= ST_WDATA;
          end
          ST_WDATA, ST_RDATA: if (inc_q) ptr_q <= ptr_q + 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign wr_en_o   = active_i && byte_valid_i && (st_q == ST_WDATA);
  assign addr_o    = ptr_q;
  assign wr_data_o = rx_byte_i;
  assign tx_en_o   = (st_q == ST_RDATA);

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && byte_valid_i && data_phase && inc_q && ptr_q == '1 |=> ptr_q == '0);  // R8
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && byte_valid_i && data_phase && !inc_q |=> $stable(ptr_q));  // R3
  AST_SKIP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && st_q == ST_SKIP |=> st_q == ST_SKIP || !active_i);  // R9
endmodule

// File: rtl/ctl_port_regs.sv
module ctl_port_regs #(
  parameter int               ADDR_W    = 7,
  parameter int               N_CTRL    = 10,
  parameter int               STAT_BASE = 10,
  parameter int               N_STAT    = 29,
  parameter logic [ADDR_W-1:0] ID_ADDR  = '1,
  parameter logic [3:0]       ID_NIB    = 4'h2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [7:0]          wr_data_i,
  input  logic [N_STAT*8-1:0] status_i,
  input  logic [3:0]          version_i,
  output logic [7:0]          rd_data_o,
  output logic [N_CTRL*8-1:0] ctrl_o
);
  localparam int STAT_END = STAT_BASE + N_STAT;

  logic [N_CTRL*8-1:0] ctrl_q;
  int a;

  for (genvar k = 0; k < N_CTRL; k++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      ctrl_q[k*8 +: 8] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(k))         ctrl_q[k*8 +: 8] <= wr_data_i;
    end
  end

  always_comb begin
    a = int'(addr_i);
    rd_data_o = '0;
    if (a < N_CTRL)                        rd_data_o = ctrl_q[a*8 +: 8];
    else if (a >= STAT_BASE && a < STAT_END) rd_data_o = status_i[(a-STAT_BASE)*8 +: 8];
    else if (addr_i == ID_ADDR)            rd_data_o = {ID_NIB, version_i};
  end

  assign ctrl_o = ctrl_q;

  AST_RO_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && int'(addr_i) >= N_CTRL |=> $stable(ctrl_o));  // R6
endmodule

// File: rtl/ctl_port_slave.sv
module ctl_port_slave #(
  parameter int         ADDR_W      = 7,
  parameter logic [6:0] DEV_ID      = 7'h10,
  parameter int         N_CTRL      = 10,
  parameter int         STAT_BASE   = 10,
  parameter int         N_STAT      = 29,
  parameter logic [3:0] ID_NIB      = 4'h2,
  parameter int         RUN_REG     = 4,
  parameter int         RUN_BIT     = 7,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                cs_ni,
  input  logic                mosi_i,
  output logic                miso_o,
  output logic                miso_oe_o,
  input  logic [N_STAT*8-1:0] status_i,
  input  logic [3:0]          version_i,
  output logic [N_CTRL*8-1:0] ctrl_o,
  output logic                run_o
);
  localparam logic [ADDR_W-1:0] ID_ADDR = '1;

  logic active, byte_valid, tx_load, tx_en, wr_en;
  logic [7:0] rx_byte, wr_data, rd_data;
  logic [ADDR_W-1:0] addr;

  ctl_port_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .tx_load_i(tx_load), .tx_data_i(rd_data), .tx_en_i(tx_en),
    .miso_o, .active_o(active), .byte_valid_o(byte_valid), .rx_byte_o(rx_byte)
  );

  ctl_port_seq #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_seq (
    .clk_i, .rst_ni, .active_i(active), .byte_valid_i(byte_valid), .rx_byte_i(rx_byte),
    .wr_en_o(wr_en), .addr_o(addr), .wr_data_o(wr_data),
    .tx_load_o(tx_load), .tx_en_o(tx_en)
  );

  ctl_port_regs #(
    .ADDR_W(ADDR_W), .N_CTRL(N_CTRL), .STAT_BASE(STAT_BASE), .N_STAT(N_STAT),
    .ID_ADDR(ID_ADDR), .ID_NIB(ID_NIB)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wr_data),
    .status_i, .version_i, .rd_data_o(rd_data), .ctrl_o
  );

  assign miso_oe_o = tx_en;
  assign run_o     = ctrl_o[RUN_REG*8 + RUN_BIT];

  AST_OE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !miso_oe_o);  // R10
  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> $stable(ctrl_o));  // R9
endmodule

// File: tb/ctl_port_slave_test.sv
`timescale 1ns/1ps
module ctl_port_slave_test;
  localparam int HP = 8;

  logic clk = 1'b0, rst_ni = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, run;
  logic [231:0] status;
  logic [79:0] ctrl;
  logic [3:0] version = 4'h5;

  int n_vec = 0, n_bad = 0;
  logic [7:0] m_ctrl [10];
  logic [6:0] m_ptr;
  logic m_inc;
  bit chk_en = 1'b0;

  always #10 clk = ~clk;

  ctl_port_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .status_i(status), .version_i(version),
    .ctrl_o(ctrl), .run_o(run)
  );

  function automatic logic [7:0] st_byte(int i);
    return 8'(i * 37 + 5);
  endfunction

  function automatic logic [79:0] m_pack();
    logic [79:0] v;
    for (int k = 0; k < 10; k++) v[k*8 +: 8] = m_ctrl[k];
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(logic [6:0] a);
    if (a < 7'd10) return m_ctrl[a];
    if (a >= 7'd10 && a <= 7'd38) return st_byte(int'(a) - 10);
    if (a == 7'h7F) return {4'h2, version};
    return 8'h00;
  endfunction

  task automatic check(bit ok, string req, logic [79:0] act, logic [79:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock comparison while the bus is idle
  always @(negedge clk) begin
    if (chk_en && rst_ni) begin
      check(ctrl === m_pack(), "R5 ctrl idle", ctrl, m_pack());
      check(run === m_ctrl[4][7], "R5 run idle", 80'(run), 80'(m_ctrl[4][7]));
      check(miso_oe === 1'b0, "R10 oe idle", 80'(miso_oe), 80'(0));
    end
  end

  task automatic cs_low();
    chk_en = 1'b0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HP) @(negedge clk);
    chk_en = 1'b1;
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, input bit exp_oe,
                          input string req, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nb; b--) begin
      mosi = tx[b];
      repeat (HP) @(negedge clk);
      rx[b] = miso;
      check(miso_oe === exp_oe, req, 80'(miso_oe), 80'(exp_oe));
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic write_txn(input logic [7:0] ptrb, input int n,
                           input logic [7:0] base, input logic [7:0] step);
    logic [7:0] rx, d;
    cs_low();
    spi_bits(8'h20, 8, 1'b0, "R1 write addr oe", rx);
    spi_bits(ptrb, 8, 1'b0, "R2 ptr oe", rx);
    m_ptr = ptrb[6:0];
    m_inc = ptrb[7];
    for (int i = 0; i < n; i++) begin
      d = base + 8'(i) * step;
      spi_bits(d, 8, 1'b0, "R3 wdata oe", rx);
      if (m_ptr < 7'd10) m_ctrl[m_ptr] = d;
      if (m_inc) m_ptr = m_ptr + 7'd1;
    end
    cs_high();
  endtask

  task automatic read_txn(input int n, input string req);
    logic [7:0] rx;
    cs_low();
    spi_bits(8'h21, 8, 1'b0, "R1 read addr oe", rx);
    for (int i = 0; i < n; i++) begin
      spi_bits(8'h00, 8, 1'b1, "R10 read oe", rx);
      check(rx === exp_rd(m_ptr), req, 80'(rx), 80'(exp_rd(m_ptr)));
      if (m_inc) m_ptr = m_ptr + 7'd1;
    end
    cs_high();
  endtask

  task automatic bad_txn(input logic [7:0] devb, input int n);
    logic [7:0] rx;
    cs_low();
    spi_bits(devb, 8, 1'b0, "R9 bad addr oe", rx);
    for (int i = 0; i < n; i++) spi_bits(8'h85 + 8'(i), 8, 1'b0, "R9 ignored oe", rx);
    cs_high();
  endtask

  initial begin
    for (int i = 0; i < 29; i++) status[i*8 +: 8] = st_byte(i);
    for (int k = 0; k < 10; k++) m_ctrl[k] = 8'h00;
    m_ptr = '0;
    m_inc = 1'b0;
    repeat (5) @(negedge clk);
    check(ctrl === 80'h0 && run === 1'b0 && miso_oe === 1'b0, "R11 reset outputs",
          {ctrl[78:0], run}, 80'h0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1'b1;
    read_txn(2, "R11 reset pointer read");
    write_txn(8'h80, 10, 8'h11, 8'h13);              // R3 R5 fill all control regs
    read_txn(5, "R6 R4 status stream after writes"); // pointer left at 0x0A
    write_txn(8'h04, 2, 8'h80, 8'h01);               // R3 no increment, last byte wins
    check(run === 1'b1, "R5 run bit", 80'(run), 80'(1));
    read_txn(3, "R4 repeat without increment");
    write_txn(8'h8A, 3, 8'hFF, 8'h00);               // R6 writes to read-only ignored
    read_txn(2, "R6 status after ignored write");
    write_txn(8'hFF, 1, 8'hAA, 8'h00);               // R7 write to ID ignored, R8 wrap
    write_txn(8'hFF, 0, 8'h00, 8'h00);
    read_txn(3, "R7 R8 id then wrap to 0x00");
    write_txn(8'h30, 0, 8'h00, 8'h00);
    read_txn(2, "R7 unimplemented reads zero");
    write_txn(8'h81, 0, 8'h00, 8'h00);
    bad_txn(8'h22, 3);                               // R9 mismatched write-type address
    bad_txn(8'h23, 2);                               // R9 mismatched read-type address
    bad_txn(8'hA0, 2);
    read_txn(2, "R9 pointer unchanged after ignored transactions");
    begin : abort_blk                                // R10 abort mid-byte
      logic [7:0] rx;
      cs_low();
      spi_bits(8'h20, 8, 1'b0, "R10 abort addr", rx);
      spi_bits(8'h84, 8, 1'b0, "R10 abort ptr", rx);
      spi_bits(8'h00, 3, 1'b0, "R10 abort data", rx);
      m_ptr = 7'h04;
      m_inc = 1'b1;
      cs_high();
    end
    read_txn(3, "R10 fresh transaction after abort");
    write_txn(8'h84, 1, 8'h00, 8'h00);
    check(run === 1'b0, "R5 run cleared", 80'(run), 80'(0));
    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule